// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

A counter that runs freely, with one capture channel and one compare channel. While its run bit is set, the counter advances by one on every clock and wraps from its maximum value back to zero. The capture channel (channel 0) watches an external pin. On the selected edge it stores the current count and pulses an interrupt. The compare channel (channel 1) pulses an interrupt and may toggle output pin 1 each time the count equals its active compare value. That gives a periodic interval output.

Software writes the compare value into a buffer. The buffer reaches the active compare register at the next wrap, or at once while the timer is stopped. Every wrap sets a sticky overflow flag and pulses an overflow interrupt. Only a write of 0 to the flag clears it. Channel 0 is fixed as a capture channel, so it never drives pin 0, whatever its enable bit holds.

Register map (3-bit address; reads are combinational from `rd_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 run, bits [2:1] edge select, bit 3 pin-0 enable, bit 4 pin-1 enable, bit 5 pin-0 idle level, bit 6 pin-1 idle level |
| 1 | compare buffer | 16-bit compare value |
| 2 | capture | last captured count (read only) |
| 3 | status | bit 0 overflow flag |
| 4 | counter | current count (read only) |

Top module: `frc_timer`

## Requirements
- R1: While control bit 0 (run) is 1, the counter (address 4) rises by one per clock and goes from FFFFh to 0000h. Once run reads 0, the counter is 0000h from the next clock on.
- R2: When run is 1 and the count equals the active compare value, `irq_cmp` is high for exactly the following cycle. With run at 0 it stays low.
- R3: Every compare match flips the internal toggle state. `out1` shows that state only while run and the pin-1 enable (bit 4) are both 1. Otherwise `out1` equals the pin-1 idle level (bit 6), and stopping the timer reloads the toggle state from that level.
- R4: The capture pin passes through a two-flop synchroniser. Edge select (bits [2:1]) means: 00 no edge, 01 rising, 10 falling, 11 both. While run is 1, a detected edge stores the count at the capture address and pulses `irq_cap` for one cycle. This happens two clocks after the pin change is first sampled.
- R5: `out0` always equals the pin-0 idle level (bit 5). The pin-0 enable (bit 3) has no effect on it.
- R6: A wrap from FFFFh to 0000h sets status bit 0 and pulses `irq_ovf` for one cycle.
- R7: Status bit 0 clears only on a write to address 3 with data bit 0 equal to 0. A write of 1 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R8: Writes to address 1 go into the compare buffer, which reads back at address 1. While run is 1, the active compare value takes the buffer contents only at a wrap. While run is 0, a write reaches the active value at the same clock.
- R9: After synchronous reset, every register reads 0, the outputs are low and the interrupts are low. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | write address |
| wr_data | input | 16 | write data |
| rd_addr | input | 3 | read address |
| rd_data | output | 16 | read data for `rd_addr` |
| cap_pin | input | 1 | asynchronous capture input |
| out0 | output | 1 | output pin 0 (held at its idle level) |
| out1 | output | 1 | compare toggle output pin 1 |
| irq_cap | output | 1 | capture interrupt pulse |
| irq_cmp | output | 1 | compare-match interrupt pulse |
| irq_ovf | output | 1 | overflow interrupt pulse |

## Verification
A wrong counter value shows up at once at the counter address. Within one cycle it also shifts the timing of every compare pulse and `out1` edge. A stale active compare value stays hidden until the count passes the old or the new value: a compare write made while running must not take effect before the next wrap, so the check spans a full 65536-cycle period. Synchroniser and edge-select errors move or drop `irq_cap` and the captured value two clocks after a pin change. A flag that is not sticky, or that loses the set/clear race, is visible on the status read in the cycle after the wrap.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_CTRL = 3'd0,
        A_CMP  = 3'd1,
        A_CAP  = 3'd2,
        A_STAT = 3'd3,
        A_CNT  = 3'd4
    } reg_addr_e;

    // bit 6 .. bit 0
    typedef struct packed {
        logic       lvl1;
        logic       lvl0;
        logic       oe1;
        logic       oe0;
        logic [1:0] edge_sel;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
        case (sel)
            2'b01:   return ~prev & cur;
            2'b10:   return prev & ~cur;
            2'b11:   return prev ^ cur;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] CMAX = '1;

    assign wrap = run && (cnt == CMAX);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == CMAX) |=> (cnt == '0));
    p_stop_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/frc_capture.sv
module frc_capture #(
    parameter int CW   = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [1:0]    edge_sel,
    input  logic          pin,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] cap_q,
    output logic          irq
);
    import frc_pkg::*;

    logic [SYNC:0] sh;
    logic          hit;

    assign hit = edge_hit(edge_sel, sh[SYNC], sh[SYNC-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            cap_q <= '0;
            irq   <= 1'b0;
        end else begin
            sh  <= {sh[SYNC-1:0], pin};
            irq <= run && hit;
            if (run && hit) cap_q <= cnt;
        end
    end

    p_cap_val_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cap_q == $past(cnt)));
    p_cap_run_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(run));
endmodule

// File: rtl/frc_compare.sv
module frc_compare #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic          buf_we,
    input  logic [CW-1:0] buf_wdata,
    input  logic          idle_lvl,
    output logic [CW-1:0] buf_q,
    output logic          tog,
    output logic          irq
);
    logic [CW-1:0] act;
    logic          hit;

    assign hit = (cnt == act);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            act   <= '0;
            irq   <= 1'b0;
            tog   <= 1'b0;
        end else begin
            if (buf_we) buf_q <= buf_wdata;
            if (buf_we && !run) act <= buf_wdata;
            else if (wrap)      act <= buf_q;
            irq <= run && hit;
            if (!run)     tog <= idle_lvl;
            else if (hit) tog <= ~tog;
        end
    end

    p_match_run_r2: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(run));
    p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (tog != $past(tog)));
    p_buffered_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(wrap)) |-> (act == $past(act)));
endmodule

// File: rtl/frc_timer.sv
module frc_timer #(
    parameter int CW   = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          cap_pin,
    output logic          out0,
    output logic          out1,
    output logic          irq_cap,
    output logic          irq_cmp,
    output logic          irq_ovf
);
    import frc_pkg::*;

    ctrl_t         ctrl;
    logic          ovf;
    logic [CW-1:0] cnt, cap_q, buf_q;
    logic          wrap, tog, ovf_clr;
    reg_addr_e     waddr, raddr;

    assign waddr   = reg_addr_e'(wr_addr);
    assign raddr   = reg_addr_e'(rd_addr);
    assign ovf_clr = wr_en && waddr == A_STAT && !wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            ovf     <= 1'b0;
            irq_ovf <= 1'b0;
        end else begin
            if (wr_en && waddr == A_CTRL) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            irq_ovf <= wrap;
            if (wrap)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    frc_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl.run), .cnt(cnt), .wrap(wrap)
    );

    frc_capture #(.CW(CW), .SYNC(SYNC)) u_cap (
        .clk(clk), .rst(rst), .run(ctrl.run), .edge_sel(ctrl.edge_sel),
        .pin(cap_pin), .cnt(cnt), .cap_q(cap_q), .irq(irq_cap)
    );

    frc_compare #(.CW(CW)) u_cmp (
        .clk(clk), .rst(rst), .run(ctrl.run), .wrap(wrap), .cnt(cnt),
        .buf_we(wr_en && waddr == A_CMP), .buf_wdata(wr_data),
        .idle_lvl(ctrl.lvl1), .buf_q(buf_q), .tog(tog), .irq(irq_cmp)
    );

    // channel 0 is a capture channel: its pin enable never hands it the pin
    assign out0 = ctrl.lvl0;
    assign out1 = (ctrl.run && ctrl.oe1) ? tog : ctrl.lvl1;

    always_comb begin
        case (raddr)
            A_CTRL:  rd_data = CW'(ctrl);
            A_CMP:   rd_data = buf_q;
            A_CAP:   rd_data = cap_q;
            A_STAT:  rd_data = CW'(ovf);
            A_CNT:   rd_data = cnt;
            default: rd_data = '0;
        endcase
    end

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
        irq_ovf |-> ovf);
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: tb/frc_timer_test.sv
module frc_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cap_pin = 1'b0;
    logic        out0, out1, irq_cap, irq_cmp, irq_ovf;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frc_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_pin(cap_pin),
        .out0(out0), .out1(out1), .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    // behavioural reference state
    int m_cnt, m_buf, m_act, m_cap, m_ctrl;
    bit m_ovf, m_tog, m_icap, m_icmp, m_iovf;
    bit m_pin[$];

    function automatic int m_read(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_buf;
            2: return m_cap;
            3: return int'(m_ovf);
            4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_out1();
        if ((m_ctrl & 1) != 0 && (m_ctrl & 16) != 0) return m_tog;
        return (m_ctrl >> 6) & 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_buf = 0; m_act = 0; m_cap = 0; m_ctrl = 0;
            m_ovf = 0; m_tog = 0; m_icap = 0; m_icmp = 0; m_iovf = 0;
            m_pin = '{0, 0, 0};
        end else begin
            bit run, wrapped, prev, cur, hit;
            int sel, nctrl, nbuf, nact, ncnt;
            run = (m_ctrl & 1) != 0;
            sel = (m_ctrl >> 1) & 3;
            nctrl = m_ctrl; nbuf = m_buf; nact = m_act;
            wrapped = run && m_cnt == 65535;
            // capture: m_pin[1] is the synchronised value, m_pin[2] the one before
            cur = m_pin[1]; prev = m_pin[2];
            hit = (sel == 1 && !prev && cur) || (sel == 2 && prev && !cur) || (sel == 3 && prev != cur);
            m_icap = run && hit;
            if (run && hit) m_cap = m_cnt;
            m_pin.push_front(cap_pin);
            void'(m_pin.pop_back());
            // compare
            m_icmp = run && m_cnt == m_act;
            if (!run) m_tog = (m_ctrl >> 6) & 1;
            else if (m_cnt == m_act) m_tog = !m_tog;
            // register writes
            if (wr_en && wr_addr == 0) nctrl = wr_data & 8'h7f;
            if (wr_en && wr_addr == 1) begin
                nbuf = wr_data;
                if (!run) nact = wr_data;
            end
            if (!(wr_en && wr_addr == 1 && !run) && wrapped) nact = m_buf;
            // overflow
            m_iovf = wrapped;
            if (wrapped) m_ovf = 1;
            else if (wr_en && wr_addr == 3 && wr_data[0] == 0) m_ovf = 0;
            ncnt = run ? (m_cnt + 1) % 65536 : 0;
            m_cnt = ncnt; m_ctrl = nctrl; m_buf = nbuf; m_act = nact;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h at cycle %0d", req, what, got, exp, cycles);
        end
    endtask

    // per-cycle comparison, between edges
    always @(posedge clk) begin
        cycles++;
        #2;
        if (!rst && !done) begin
            chk("R2", "irq_cmp", int'(irq_cmp), int'(m_icmp));
            chk("R3", "out1", int'(out1), int'(m_out1()));
            chk("R4", "irq_cap", int'(irq_cap), int'(m_icap));
            chk("R5", "out0", int'(out0), (m_ctrl >> 5) & 1);
            chk("R6", "irq_ovf", int'(irq_ovf), int'(m_iovf));
            chk("R9", "rd_data", int'(rd_data), m_read(int'(rd_addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_at(input int a);
        @(negedge clk);
        rd_addr = a[2:0];
        @(posedge clk); #2;
    endtask

    task automatic pulse_pin(input int hi, input int lo);
        @(negedge clk); cap_pin = 1'b1; idle(hi);
        @(negedge clk); cap_pin = 1'b0; idle(lo);
    endtask

    task automatic finish_up();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        // R9 reset state
        chk("R9", "reset out0", int'(out0), 0);
        chk("R9", "reset out1", int'(out1), 0);
        chk("R9", "reset irqs", int'({irq_cap, irq_cmp, irq_ovf}), 0);
        for (int a = 0; a < 8; a++) begin
            rd_at(a);
            chk("R9", "reset read", int'(rd_data), 0);
        end
        // idle levels while stopped; pin-0 enable ignored (R5)
        wr(0, 'h58);            // lvl1, oe1, oe0, run=0
        rd_at(0);
        chk("R3", "idle out1 high", int'(out1), 1);
        chk("R5", "out0 ignores enable", int'(out0), 0);
        wr(0, 'h78);            // lvl0 too
        chk("R5", "out0 follows level", int'(out0), 1);
        // R8 immediate transfer while stopped, then run with falling edge
        wr(1, 10);
        wr(0, 'h5d);            // run, falling edge (10), oe1, oe0, lvl1
        rd_at(4);
        idle(20);
        rd_at(4);
        chk("R1", "counter advanced", int'(rd_data), m_cnt);
        rd_at(2);
        pulse_pin(3, 5);        // R4 falling edge captured
        pulse_pin(1, 6);
        wr(0, 'h5b);            // rising (01)
        pulse_pin(4, 4);
        wr(0, 'h5f);            // both (11)
        pulse_pin(2, 5);
        pulse_pin(1, 1);
        wr(0, 'h59);            // none (00)
        pulse_pin(3, 3);
        chk("R4", "captured value", int'(rd_data), m_cap);
        // R8 buffered write while running: takes effect only after wrap
        wr(1, 30);
        rd_at(1);
        chk("R8", "buffer readback", int'(rd_data), 30);
        rd_at(3);
        while (m_cnt != 2) @(negedge clk);
        chk("R6", "flag after wrap", int'(rd_data), 1);
        wr(3, 1);
        chk("R7", "write 1 keeps flag", int'(rd_data), 1);
        wr(3, 0);
        chk("R7", "write 0 clears flag", int'(rd_data), 0);
        idle(100);
        // R7 set wins against a clearing write in the same cycle
        while (m_cnt != 65535) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = '0;
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #2;
        chk("R7", "set beats clear", int'(rd_data), 1);
        // R1 stop returns counter to zero; R3 out1 back to idle level
        wr(0, 'h40);
        rd_at(4);
        chk("R1", "stopped counter", int'(rd_data), 0);
        chk("R3", "stopped out1", int'(out1), 1);
        finish_up();
    end

    initial begin
        wait (cycles > 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end
endmodule